// File: doc/BRIEF.md
# Multi-Pipe Issue Scoreboard with Forwarding

This block is the issue-stage control for a core that issues in order but lets results complete out of order across three execution pipes: a single-cycle ALU pipe, a multiply/divide pipe and a load/store pipe. It sees one decoded instruction per cycle: a pipe code, a divide flag, an optional destination register and up to two optional source registers. From these it decides in the same cycle whether the instruction issues or is held. When the instruction issues it is routed to exactly one pipe.

A per-register scoreboard tracks, for each of sixteen architectural registers, whether a write is pending, which pipe produces it, how many cycles remain until the value exists, and how long it stays in the pipes before it reaches the register file. A source whose value does not yet exist holds the instruction at issue. A source whose value exists but has not been written back gets a forward-select code that names the producing pipe. Every pipe forwards, so every result is usable as soon as it is produced.

A divide occupies the multiply pipe for its whole latency. Later instructions with no dependence on it keep issuing to the ALU and load/store pipes. A write to a register that still has a pending write from a different pipe is held, so that register writes cannot land out of order.

Top module: `issue_scoreboard`

## Requirements
- R1: While `in_valid` is low, `stall` and all three issue outputs are low, and both forward selects are 0.
- R2: A valid instruction that is not stalled asserts exactly one issue output, chosen by `in_pipe`: 0 ALU (`go_alu`), 1 multiply/divide (`go_mul`), 2 load/store (`go_lsu`). Pipe code 3 is reserved; such an instruction always stalls and never issues.
- R3: An enabled source register whose pending result is not yet produced stalls the instruction. A result is produced 1 cycle after issue for the ALU, 2 cycles for a multiply, 2 cycles for a load/store and 32 cycles for a divide.
- R4: An enabled source whose pending result has been produced but not written back gets forward code 1 (ALU), 2 (multiply/divide) or 3 (load/store). This window lasts 2 cycles, after which the register is free and the code is 0. A disabled or free source always gives code 0.
- R5: An ALU result is usable by an instruction in the very next cycle after its producer issued, through forward code 1, without a stall.
- R6: A divide blocks multiply-pipe issue for the 31 cycles after it issues. A multiply-pipe instruction issues again 32 cycles after the divide issued. Independent ALU and load/store instructions keep issuing during those cycles.
- R7: An instruction that writes a register with a pending write from a different pipe stalls until that earlier write has left the scoreboard.
- R8: A new write to a register from the same pipe replaces the pending entry, so readers wait for, and forward from, the most recent producer.
- R9: After reset no register is pending: any instruction to the ALU or load/store pipe issues at once with forward codes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_pipe | input | 2 | Target pipe: 0 ALU, 1 multiply/divide, 2 load/store, 3 reserved |
| in_div | input | 1 | Multiply-pipe instruction is a divide |
| in_wr_en | input | 1 | Instruction writes a destination register |
| in_rd | input | 4 | Destination register number |
| in_ra_en | input | 1 | First source operand is a register |
| in_ra | input | 4 | First source register number |
| in_rb_en | input | 1 | Second source operand is a register |
| in_rb | input | 4 | Second source register number |
| stall | output | 1 | Instruction is held at issue this cycle |
| go_alu | output | 1 | Instruction issues to the ALU pipe |
| go_mul | output | 1 | Instruction issues to the multiply/divide pipe |
| go_lsu | output | 1 | Instruction issues to the load/store pipe |
| fwd_a | output | 2 | Forward select for the first source |
| fwd_b | output | 2 | Forward select for the second source |

## Verification
Stall, issue and forward outputs are combinational in the cycle the instruction is presented, so the bench drives each instruction at the falling edge and compares one time unit later, before the next rising edge. Scoreboard effects of an issue show up from the cycle after the issuing edge. A reader is due to stall in cycles issue+1 up to issue+latency−1, to get a forward code in cycles issue+latency and issue+latency+1, and to read the register file from issue+latency+2. After a divide, multiply-pipe issue is due again at cycle issue+32. The bench model keeps the absolute cycle at which each register becomes ready and free, and compares against those numbers every cycle. Directed sequences pin these exact cycles at each boundary.

// File: rtl/scb_pkg.sv
package scb_pkg;

  typedef enum logic [1:0] {
    PIPE_ALU = 2'd0,
    PIPE_MUL = 2'd1,
    PIPE_LSU = 2'd2,
    PIPE_RSV = 2'd3
  } pipe_e;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_ALU = 2'd1,
    FWD_MUL = 2'd2,
    FWD_LSU = 2'd3
  } fwd_e;

  // Forward source code for a producing pipe
  function automatic fwd_e fwd_from(logic [1:0] pipe);
    case (pipe)
      PIPE_ALU: fwd_from = FWD_ALU;
      PIPE_MUL: fwd_from = FWD_MUL;
      PIPE_LSU: fwd_from = FWD_LSU;
      default:  fwd_from = FWD_RF;
    endcase
  endfunction

endpackage

// File: rtl/scb_entry.sv
// One scoreboard entry: pending flag, producing pipe, cycles until the
// result exists and cycles it stays forwardable before writeback.
module scb_entry
  import scb_pkg::*;
#(
  parameter int CW      = 6,
  parameter int FWD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [1:0]    set_pipe_i,
  input  logic [CW-1:0] set_lat_m1_i,
  output logic          busy_o,
  output logic          ready_o,
  output logic [1:0]    pipe_o
);

  localparam int WW = (FWD_CYC > 1) ? $clog2(FWD_CYC) : 1;

  logic          busy_q, busy_d;
  logic [1:0]    pipe_q, pipe_d;
  logic [CW-1:0] rdy_q, rdy_d;
  logic [WW-1:0] wb_q, wb_d;
  logic          en;

  assign en = set_i | busy_q;

  always_comb begin
    busy_d = busy_q;
    pipe_d = pipe_q;
    rdy_d  = rdy_q;
    wb_d   = wb_q;
    if (set_i) begin
      busy_d = 1'b1;
      pipe_d = set_pipe_i;
      rdy_d  = set_lat_m1_i;
      wb_d   = WW'(FWD_CYC - 1);
    end else if (busy_q) begin
      if (rdy_q != '0) begin
        rdy_d = rdy_q - 1'b1;
      end else if (wb_q != '0) begin
        wb_d = wb_q - 1'b1;
      end else begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pipe_q <= PIPE_ALU;
      rdy_q  <= '0;
      wb_q   <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      pipe_q <= pipe_d;
      rdy_q  <= rdy_d;
      wb_q   <= wb_d;
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && (rdy_q == '0);
  assign pipe_o  = pipe_q;

endmodule

// File: rtl/scb_src_check.sv
// Per-operand lookup: hold request and forward select.
module scb_src_check
  import scb_pkg::*;
#(
  parameter int NREG = 16,
  parameter int RW   = 4
) (
  input  logic                 en_i,
  input  logic [RW-1:0]        idx_i,
  input  logic [NREG-1:0]      busy_i,
  input  logic [NREG-1:0]      ready_i,
  input  logic [NREG-1:0][1:0] pipe_i,
  output logic                 wait_o,
  output logic [1:0]           fwd_o
);

  always_comb begin
    wait_o = en_i && busy_i[idx_i] && !ready_i[idx_i];
    fwd_o  = FWD_RF;
    if (en_i && ready_i[idx_i]) begin
      fwd_o = fwd_from(pipe_i[idx_i]);
    end
  end

endmodule

// File: rtl/scb_div_track.sv
// Occupancy of the multiply pipe while an iterative divide runs.
module scb_div_track #(
  parameter int DIV_LAT = 32,
  parameter int CW      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en = start_i | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = CW'(DIV_LAT - 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import scb_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int ALU_LAT = 1,
  parameter int MUL_LAT = 2,
  parameter int LSU_LAT = 2,
  parameter int DIV_LAT = 32,
  parameter int FWD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_pipe,
  input  logic       in_div,
  input  logic       in_wr_en,
  input  logic [3:0] in_rd,
  input  logic       in_ra_en,
  input  logic [3:0] in_ra,
  input  logic       in_rb_en,
  input  logic [3:0] in_rb,
  output logic       stall,
  output logic       go_alu,
  output logic       go_mul,
  output logic       go_lsu,
  output logic [1:0] fwd_a,
  output logic [1:0] fwd_b
);

  localparam int RW   = $clog2(NREG);
  localparam int CW   = $clog2(DIV_LAT + 1);
  localparam int NSRC = 2;

  logic [NREG-1:0]      busy_v;
  logic [NREG-1:0]      ready_v;
  logic [NREG-1:0][1:0] pipe_v;

  logic [NSRC-1:0]          src_en;
  logic [NSRC-1:0][RW-1:0]  src_idx;
  logic [NSRC-1:0]          src_wait;
  logic [NSRC-1:0][1:0]     src_fwd;

  logic          div_busy;
  logic          waw_hold;
  logic          pipe_hold;
  logic          go;
  logic [CW-1:0] lat_m1;

  // Cycles from issue to result, minus one
  always_comb begin
    case (in_pipe)
      PIPE_ALU: lat_m1 = CW'(ALU_LAT - 1);
      PIPE_MUL: lat_m1 = in_div ? CW'(DIV_LAT - 1) : CW'(MUL_LAT - 1);
      PIPE_LSU: lat_m1 = CW'(LSU_LAT - 1);
      default:  lat_m1 = '0;
    endcase
  end

  // Scoreboard entries
  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic set;
    assign set = go && in_wr_en && (in_rd == RW'(g));
    scb_entry #(.CW(CW), .FWD_CYC(FWD_CYC)) i_entry (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_i        (set),
      .set_pipe_i   (in_pipe),
      .set_lat_m1_i (lat_m1),
      .busy_o       (busy_v[g]),
      .ready_o      (ready_v[g]),
      .pipe_o       (pipe_v[g])
    );
  end

  // Operand lookups
  assign src_en[0]  = in_valid && in_ra_en;
  assign src_en[1]  = in_valid && in_rb_en;
  assign src_idx[0] = in_ra;
  assign src_idx[1] = in_rb;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    scb_src_check #(.NREG(NREG), .RW(RW)) i_src (
      .en_i    (src_en[s]),
      .idx_i   (src_idx[s]),
      .busy_i  (busy_v),
      .ready_i (ready_v),
      .pipe_i  (pipe_v),
      .wait_o  (src_wait[s]),
      .fwd_o   (src_fwd[s])
    );
  end

  scb_div_track #(.DIV_LAT(DIV_LAT), .CW(CW)) i_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (go_mul && in_div),
    .busy_o  (div_busy)
  );

  // Issue decision
  assign waw_hold  = in_wr_en && busy_v[in_rd] && (pipe_v[in_rd] != in_pipe);
  assign pipe_hold = (in_pipe == PIPE_RSV) || ((in_pipe == PIPE_MUL) && div_busy);
  assign stall     = in_valid && (pipe_hold || waw_hold || (|src_wait));
  assign go        = in_valid && !stall;

  assign go_alu = go && (in_pipe == PIPE_ALU);
  assign go_mul = go && (in_pipe == PIPE_MUL);
  assign go_lsu = go && (in_pipe == PIPE_LSU);
  assign fwd_a  = src_fwd[0];
  assign fwd_b  = src_fwd[1];

endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int DIV_LAT = 32,
  parameter int RW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    in_pipe,
  input logic          in_div,
  input logic          in_wr_en,
  input logic [RW-1:0] in_rd,
  input logic          in_ra_en,
  input logic [RW-1:0] in_ra,
  input logic          in_rb_en,
  input logic          stall,
  input logic          go_alu,
  input logic          go_mul,
  input logic          go_lsu,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b
);

  localparam int CW = $clog2(DIV_LAT + 1);

  logic          alu_wr_q;
  logic [RW-1:0] alu_rd_q;
  logic [CW-1:0] div_left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alu_wr_q   <= 1'b0;
      alu_rd_q   <= '0;
      div_left_q <= '0;
    end else begin
      alu_wr_q <= go_alu && in_wr_en;
      alu_rd_q <= in_rd;
      if (go_mul && in_div) begin
        div_left_q <= CW'(DIV_LAT - 1);
      end else if (div_left_q != '0) begin
        div_left_q <= div_left_q - 1'b1;
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!stall && !go_alu && !go_mul && !go_lsu && fwd_a == 2'd0 && fwd_b == 2'd0));

  // R2
  issue_or_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (stall != (go_alu || go_mul || go_lsu)) && $onehot0({go_alu, go_mul, go_lsu}));

  // R2
  pipe_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_alu || go_mul || go_lsu) |-> ({go_lsu, go_mul, go_alu} == (3'b001 << in_pipe)));

  // R4
  src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!in_ra_en |-> fwd_a == 2'd0) and (!in_rb_en |-> fwd_b == 2'd0)));

  // R5
  alu_next_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_wr_q && in_valid && in_ra_en && in_ra == alu_rd_q) |-> fwd_a == 2'd1);

  // R6
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_left_q != '0) |-> !go_mul);

endmodule

bind issue_scoreboard scb_checker #(.DIV_LAT(DIV_LAT), .RW(RW)) i_scb_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_pipe  (in_pipe),
  .in_div   (in_div),
  .in_wr_en (in_wr_en),
  .in_rd    (in_rd),
  .in_ra_en (in_ra_en),
  .in_ra    (in_ra),
  .in_rb_en (in_rb_en),
  .stall    (stall),
  .go_alu   (go_alu),
  .go_mul   (go_mul),
  .go_lsu   (go_lsu),
  .fwd_a    (fwd_a),
  .fwd_b    (fwd_b)
);

// File: tb/test_issue_scoreboard.sv
module test_issue_scoreboard;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 16;
  localparam int LAT_ALU    = 1;
  localparam int LAT_MUL    = 2;
  localparam int LAT_LSU    = 2;
  localparam int LAT_DIV    = 32;
  localparam int WB_WIN     = 2;
  localparam int RAND_CYC   = 4000;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [1:0] in_pipe;
  logic       in_div;
  logic       in_wr_en;
  logic [3:0] in_rd;
  logic       in_ra_en;
  logic [3:0] in_ra;
  logic       in_rb_en;
  logic [3:0] in_rb;
  logic       stall;
  logic       go_alu;
  logic       go_mul;
  logic       go_lsu;
  logic [1:0] fwd_a;
  logic [1:0] fwd_b;

  issue_scoreboard i_issue_scoreboard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pipe(in_pipe),
    .in_div(in_div), .in_wr_en(in_wr_en), .in_rd(in_rd),
    .in_ra_en(in_ra_en), .in_ra(in_ra), .in_rb_en(in_rb_en), .in_rb(in_rb),
    .stall(stall), .go_alu(go_alu), .go_mul(go_mul), .go_lsu(go_lsu),
    .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Bench model: absolute cycle numbers per register
  int m_pipe [NREG];
  int m_rdy  [NREG];
  int m_free [NREG];
  int m_divfree;
  int cyc;
  int n_chk;
  int n_fail;
  bit done;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int lat_of(input int p, input bit d);
    case (p)
      0:       return LAT_ALU;
      1:       return d ? LAT_DIV : LAT_MUL;
      2:       return LAT_LSU;
      default: return 1;
    endcase
  endfunction

  function automatic int fwd_exp(input bit en, input int r);
    if (in_valid && en && cyc < m_free[r] && cyc >= m_rdy[r]) return m_pipe[r] + 1;
    return 0;
  endfunction

  function automatic bit raw_exp(input bit en, input int r);
    return in_valid && en && cyc < m_free[r] && cyc < m_rdy[r];
  endfunction

  task automatic put(input bit v, input int p, input bit d, input bit w, input int rd,
                     input bit ae, input int ra, input bit be, input int rb);
    in_valid = v;
    in_pipe  = 2'(p);
    in_div   = d;
    in_wr_en = w;
    in_rd    = 4'(rd);
    in_ra_en = ae;
    in_ra    = 4'(ra);
    in_rb_en = be;
    in_rb    = 4'(rb);
    #1;
  endtask

  // Compare one cycle against the model, advance model and clock
  task automatic step();
    bit    waw, divb, stl, g;
    int    p;
    int    gv;
    string tag;
    #1;
    p    = int'(in_pipe);
    waw  = in_wr_en && cyc < m_free[in_rd] && m_pipe[in_rd] != p;
    divb = (p == 1) && cyc < m_divfree;
    stl  = in_valid && (p == 3 || raw_exp(in_ra_en, in_ra) || raw_exp(in_rb_en, in_rb) || waw || divb);
    g    = in_valid && !stl;
    gv   = g ? (1 << p) : 0;
    if (!in_valid) tag = "R1";
    else if (p == 3) tag = "R2";
    else if (divb) tag = "R6";
    else if (waw) tag = "R7";
    else if (stl) tag = "R3";
    else tag = "R2";
    chk(tag, "stall", int'(stall), int'(stl));
    chk(tag, "issue {lsu,mul,alu}", int'({go_lsu, go_mul, go_alu}), gv);
    chk("R4", "fwd_a", int'(fwd_a), fwd_exp(in_ra_en, in_ra));
    chk("R4", "fwd_b", int'(fwd_b), fwd_exp(in_rb_en, in_rb));
    if (g) begin
      if (in_wr_en) begin
        m_pipe[in_rd] = p;
        m_rdy[in_rd]  = cyc + lat_of(p, in_div);
        m_free[in_rd] = cyc + lat_of(p, in_div) + WB_WIN;
      end
      if (p == 1 && in_div) m_divfree = cyc + LAT_DIV;
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      put(0, 0, 0, 0, 0, 0, 0, 0, 0);
      step();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int d0;
    bit hv, hd, hw, ha, hb;
    int hp, hrd, hra, hrb;
    bit fresh;
    void'($urandom(32'h5eed_c0de));
    n_chk = 0; n_fail = 0; done = 0; cyc = 0; m_divfree = 0;
    for (int r = 0; r < NREG; r++) begin
      m_pipe[r] = 0; m_rdy[r] = 0; m_free[r] = 0;
    end
    rst_n = 1'b0;
    put(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;

    // R9: nothing pending after reset
    put(1, 0, 0, 1, 1, 1, 3, 1, 5);
    chk("R9", "go_alu", int'(go_alu), 1);
    chk("R9", "fwd_a", int'(fwd_a), 0);
    chk("R9", "fwd_b", int'(fwd_b), 0);
    step();
    // R5: ALU result forwarded in the next cycle
    put(1, 0, 0, 1, 7, 1, 1, 1, 2);
    chk("R5", "stall", int'(stall), 0);
    chk("R5", "fwd_a", int'(fwd_a), 1);
    step();
    // R4: second forwarding cycle, then register file
    put(1, 2, 0, 1, 8, 0, 0, 1, 1);
    chk("R4", "fwd_b window end", int'(fwd_b), 1);
    step();
    put(1, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R4", "fwd_a after writeback", int'(fwd_a), 0);
    step();
    idle(4);

    // R3: load result not ready yet
    put(1, 2, 0, 1, 12, 0, 0, 0, 0);
    step();
    put(1, 0, 0, 0, 0, 1, 12, 0, 0);
    chk("R3", "stall before load result", int'(stall), 1);
    step();
    put(1, 0, 0, 0, 0, 1, 12, 0, 0);
    chk("R3", "stall released", int'(stall), 0);
    chk("R4", "fwd_a from load", int'(fwd_a), 3);
    step();
    idle(4);

    // R7: different-pipe write to a pending register
    put(1, 0, 0, 1, 5, 0, 0, 0, 0);
    step();
    for (int k = 0; k < 2; k++) begin
      put(1, 2, 0, 1, 5, 0, 0, 0, 0);
      chk("R7", "stall on pending write", int'(stall), 1);
      step();
    end
    put(1, 2, 0, 1, 5, 0, 0, 0, 0);
    chk("R7", "go_lsu after writeback", int'(go_lsu), 1);
    step();
    idle(4);

    // R8: same-pipe rewrite, latest producer wins
    put(1, 1, 0, 1, 6, 0, 0, 0, 0);
    step();
    put(1, 1, 0, 1, 6, 0, 0, 0, 0);
    chk("R8", "same-pipe rewrite issues", int'(go_mul), 1);
    step();
    put(1, 0, 0, 0, 0, 1, 6, 0, 0);
    chk("R8", "waits for latest", int'(stall), 1);
    step();
    put(1, 0, 0, 0, 0, 1, 6, 0, 0);
    chk("R8", "stall released", int'(stall), 0);
    chk("R8", "fwd_a from latest", int'(fwd_a), 2);
    step();
    idle(4);

    // R6: divide occupies only the multiply pipe
    d0 = cyc;
    put(1, 1, 1, 1, 2, 0, 0, 0, 0);
    chk("R6", "divide issues", int'(go_mul), 1);
    step();
    for (int k = 1; k <= 10; k++) begin
      if (k % 2 == 1) put(1, 0, 0, 1, 10, 0, 0, 0, 0);
      else            put(1, 2, 0, 1, 11, 0, 0, 0, 0);
      chk("R6", "independent issue during divide", int'(go_alu | go_lsu), 1);
      step();
    end
    while (cyc < d0 + LAT_DIV) begin
      put(1, 1, 0, 1, 9, 0, 0, 0, 0);
      chk("R6", "multiply held by divide", int'(stall), 1);
      step();
    end
    put(1, 1, 0, 1, 9, 0, 0, 0, 0);
    chk("R6", "multiply issues at divide end", int'(go_mul), 1);
    step();
    put(1, 0, 0, 0, 0, 1, 2, 0, 0);
    chk("R4", "fwd_a from divide", int'(fwd_a), 2);
    step();
    idle(4);

    // R2: reserved pipe code never issues
    put(1, 3, 0, 1, 4, 0, 0, 0, 0);
    chk("R2", "reserved pipe stalls", int'(stall), 1);
    chk("R2", "reserved pipe no issue", int'({go_lsu, go_mul, go_alu}), 0);
    step();
    idle(2);

    // Random mix, instruction held while stalled
    fresh = 1;
    hv = 0; hp = 0; hd = 0; hw = 0; hrd = 0; ha = 0; hra = 0; hb = 0; hrb = 0;
    for (int n = 0; n < RAND_CYC; n++) begin
      if (fresh) begin
        hv  = ($urandom_range(0, 99) < 85);
        hp  = ($urandom_range(0, 99) < 3) ? 3 : int'($urandom_range(0, 2));
        hd  = (hp == 1) && ($urandom_range(0, 9) == 0);
        hw  = ($urandom_range(0, 9) < 8);
        hrd = int'($urandom_range(0, 7));
        ha  = ($urandom_range(0, 9) < 7);
        hra = int'($urandom_range(0, 7));
        hb  = ($urandom_range(0, 9) < 5);
        hrb = int'($urandom_range(0, 7));
      end
      put(hv, hp, hd, hw, hrd, ha, hra, hb, hrb);
      fresh = !hv || !stall;
      step();
    end

    idle(40);
    done = 1;
    summary();
    $finish;
  end

endmodule